// File: doc/BRIEF.md
# Daisy-Chain SPI Command and Acknowledge Engine

This engine sits on the host side of one SPI link that is shared by a daisy chain of hashing chips. Every chip passes the bytes it receives on to the next one. For each request the engine builds a frame from a command byte, an address byte and up to `MAX_PAY` payload bytes, and sends that frame one byte at a time through a simple byte-exchange port. It then keeps the link clock running with zero bytes long enough for the command to reach the far end of the chain and for the reply to come back.

For acknowledged commands the engine reads the returned stream as 16-bit words. It looks for the word that carries the expected reply code followed by the addressed chip id. After that word it captures the requested number of response bytes. The hunt is bounded by a word limit that grows with the chain length, and hitting the limit ends the request with a timeout. Write-job frames and unicast register writes are posted. Such a frame is followed only by zero padding that scales with the chain length, and no acknowledge is awaited.

Top module: `dchain_cmd_engine`

## Requirements
- R1: A request puts out byte 0 = command, byte 1 = address, then payload byte i (taken from `req_payload[8i+:8]`) for i < `req_pay_len`. The frame is extended with zero bytes to the even length 2*floor((req_pay_len+3)/2).
- R2: For a non-posted request, after the frame the engine sends zero bytes and groups the received bytes into words of two. The first word starts at the first byte after the frame. A word is the acknowledge when its first byte equals the expected code and its second byte equals the request address. The expected code is 0x1A when the command is 0x0A and is the command itself otherwise. Bytes received while the frame is being sent are ignored.
- R3: If no acknowledge arrives within L = 2*N+1 words, plus 510 more when N (`chain_len`) is 0, the request ends with `timeout`=1 and `ack_ok`=0 after exactly L words.
- R4: After the acknowledge, exactly `req_rsp_len` further bytes are received. Byte i is stored in `rsp_data[8i+:8]` and the unfilled bytes read zero. With `req_rsp_len`=0 the request ends right after the acknowledge word.
- R5: A request is posted when command bits [3:0] equal 0x7, or when the command is 0x09 with a nonzero address. A posted frame is followed by exactly 4*N zero bytes and no acknowledge hunt, and it ends with `ack_ok`=1 and `timeout`=0.
- R6: `done` is high for exactly one cycle per request, and no byte transfer follows it. `ack_ok` and `timeout` keep their values until the next accepted start. A start pulse while a request is in progress is ignored.
- R7: `bx_valid` and `bx_tx` hold steady until the port answers with `bx_ready`. Each handshake moves exactly one byte.
- R8: A code/address byte pair that straddles two received words is not taken as an acknowledge, and neither is a word whose address byte differs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_start | input | 1 | Start pulse, accepted only while idle |
| req_cmd | input | 8 | Command byte |
| req_addr | input | 8 | Chip address, 0 = broadcast |
| req_payload | input | MAX_PAY*8 | Payload bytes, byte i at [8i+:8] |
| req_pay_len | input | $clog2(MAX_PAY+1) | Payload byte count |
| req_rsp_len | input | $clog2(MAX_RSP+1) | Response byte count after the acknowledge |
| chain_len | input | $clog2(MAX_CHAIN+1) | Known chain length, 0 = unknown |
| bx_valid | output | 1 | Byte exchange requested |
| bx_tx | output | 8 | Byte to send |
| bx_ready | input | 1 | Exchange completed this cycle |
| bx_rx | input | 8 | Byte received, valid with bx_ready |
| done | output | 1 | One-cycle completion pulse |
| ack_ok | output | 1 | Request acknowledged or posted |
| timeout | output | 1 | Acknowledge hunt exhausted |
| rsp_data | output | MAX_RSP*8 | Response bytes, byte i at [8i+:8] |

## Verification
The byte that drives each handshake is registered. The port model therefore logs `bx_tx` and supplies `bx_rx` on the falling edge where it raises `bx_ready`, and the engine takes that byte on the next rising edge. `done`, `ack_ok`, `timeout` and `rsp_data` all change on the rising edge that completes the last byte of the request. The bench samples them on the falling edge where `done` is first seen high. It checks that `done` is low again one falling edge later, and after a few more idle cycles it checks that the transfer count and the flags have not moved. Random port stall lengths of zero to two cycles mean the bench never relies on a fixed latency. It checks only the handshake order.

// File: rtl/dchain_pkg.sv
// Shared definitions for the daisy-chain command engine: command codes,
// control states and the small decode functions used by the top level.
package dchain_pkg;

    localparam logic [7:0] CMD_BIST_START = 8'h01;
    localparam logic [7:0] CMD_BIST_FIX   = 8'h03;
    localparam logic [7:0] CMD_RESET      = 8'h04;
    localparam logic [7:0] CMD_JOB        = 8'h07;
    localparam logic [7:0] CMD_RESULT     = 8'h08;
    localparam logic [7:0] CMD_REG_WR     = 8'h09;
    localparam logic [7:0] CMD_REG_RD     = 8'h0A;
    localparam logic [7:0] CMD_REG_RD_ANS = 8'h1A;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_PAD,
        ST_POLL,
        ST_RESP
    } eng_state_t;

    // Reply code that acknowledges a given command.
    function automatic logic [7:0] ack_code_of(input logic [7:0] cmd);
        return (cmd == CMD_REG_RD) ? CMD_REG_RD_ANS : cmd;
    endfunction

    // Frames that are pushed through the chain without an acknowledge hunt.
    function automatic logic is_posted(input logic [7:0] cmd, input logic [7:0] addr);
        return (cmd[3:0] == CMD_JOB[3:0]) || (cmd == CMD_REG_WR && addr != 8'h00);
    endfunction

endpackage

// File: rtl/dchain_frame.sv
// Frame byte selector. Given a byte index it returns the byte to send:
// command, address, payload, then zero fill. It also returns the frame
// length rounded up to an even byte count. Purely combinational; assumes
// pay_len <= MAX_PAY.
module dchain_frame #(
    parameter int MAX_PAY = 56,
    parameter int CW      = 16,
    localparam int LW     = $clog2(MAX_PAY + 1)
) (
    input  logic [7:0]           cmd,
    input  logic [7:0]           addr,
    input  logic [MAX_PAY*8-1:0] payload,
    input  logic [LW-1:0]        pay_len,
    input  logic [CW-1:0]        idx,
    output logic [7:0]           fbyte,
    output logic [CW-1:0]        frame_len
);

    // Even frame length: two header bytes plus payload, rounded up.
    assign frame_len = ((CW'(pay_len) + CW'(3)) >> 1) << 1;

    // Byte mux over the header and the payload positions.
    always_comb begin
        fbyte = 8'h00;
        if (idx == CW'(0)) begin
            fbyte = cmd;
        end else if (idx == CW'(1)) begin
            fbyte = addr;
        end else begin
            for (int i = 0; i < MAX_PAY; i++) begin
                if (idx == CW'(i + 2) && CW'(i) < CW'(pay_len)) begin
                    fbyte = payload[i*8 +: 8];
                end
            end
        end
    end

endmodule

// File: rtl/dchain_word.sv
// Acknowledge word matcher. Pairs received bytes into 16-bit words,
// counting from the first strobe after clear is released, and flags the
// word whose high byte equals exp_code and low byte equals exp_id.
module dchain_word (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       strobe,
    input  logic [7:0] rx,
    input  logic [7:0] exp_code,
    input  logic [7:0] exp_id,
    output logic       word_done,
    output logic       word_match
);

    logic       second;
    logic [7:0] first_byte;

    // Track the byte position within a word and hold the first byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            second     <= 1'b0;
            first_byte <= 8'h00;
        end else if (strobe) begin
            second <= ~second;
            if (!second) begin
                first_byte <= rx;
            end
        end
    end

    assign word_done  = strobe && second;
    assign word_match = word_done && (first_byte == exp_code) && (rx == exp_id);

endmodule

// File: rtl/dchain_limit.sv
// Acknowledge hunt limit in words: 2*N+1, plus 2*MAX_CHAIN more when the
// chain length is still unknown (N = 0). Combinational.
module dchain_limit #(
    parameter int MAX_CHAIN = 255,
    parameter int CW        = 16,
    localparam int NW       = $clog2(MAX_CHAIN + 1)
) (
    input  logic [NW-1:0] chain_len,
    output logic [CW-1:0] limit
);

    // Base limit plus the enumeration allowance.
    assign limit = (CW'(chain_len) << 1) + CW'(1)
                 + ((chain_len == '0) ? CW'(2 * MAX_CHAIN) : CW'(0));

endmodule

// File: rtl/dchain_cmd_engine.sv
// Daisy-chain command engine. It accepts one request while idle, sends the
// frame through the byte port, then either pads with 4*N zero bytes
// (posted frames) or hunts for the acknowledge word and captures the
// response bytes. Assumes req_pay_len <= MAX_PAY, req_rsp_len <= MAX_RSP
// and chain_len <= MAX_CHAIN. Request inputs are sampled on the start cycle.
module dchain_cmd_engine
    import dchain_pkg::*;
#(
    parameter int MAX_PAY   = 56,
    parameter int MAX_RSP   = 8,
    parameter int MAX_CHAIN = 255,
    localparam int LW       = $clog2(MAX_PAY + 1),
    localparam int RW       = $clog2(MAX_RSP + 1),
    localparam int NW       = $clog2(MAX_CHAIN + 1),
    localparam int CW       = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_start,
    input  logic [7:0]           req_cmd,
    input  logic [7:0]           req_addr,
    input  logic [MAX_PAY*8-1:0] req_payload,
    input  logic [LW-1:0]        req_pay_len,
    input  logic [RW-1:0]        req_rsp_len,
    input  logic [NW-1:0]        chain_len,
    output logic                 bx_valid,
    output logic [7:0]           bx_tx,
    input  logic                 bx_ready,
    input  logic [7:0]           bx_rx,
    output logic                 done,
    output logic                 ack_ok,
    output logic                 timeout,
    output logic [MAX_RSP*8-1:0] rsp_data
);

    eng_state_t           st;
    logic [7:0]           cmd_q, addr_q, code_q;
    logic [MAX_PAY*8-1:0] pay_q;
    logic [LW-1:0]        plen_q;
    logic [RW-1:0]        rlen_q;
    logic [NW-1:0]        nlen_q;
    logic                 posted_q;
    logic [CW-1:0]        idx, words;
    logic [CW-1:0]        frame_len, pad_len, limit;
    logic [7:0]           fbyte;
    logic                 xfer, w_done, w_match;
    logic                 done_q, ack_q, to_q;
    logic [MAX_RSP*8-1:0] rsp_q;

    dchain_frame #(.MAX_PAY(MAX_PAY), .CW(CW)) frame_i (
        .cmd(cmd_q), .addr(addr_q), .payload(pay_q), .pay_len(plen_q),
        .idx(idx), .fbyte(fbyte), .frame_len(frame_len)
    );

    dchain_word word_i (
        .clk(clk), .rst_n(rst_n), .clear(st != ST_POLL),
        .strobe(xfer && st == ST_POLL), .rx(bx_rx),
        .exp_code(code_q), .exp_id(addr_q),
        .word_done(w_done), .word_match(w_match)
    );

    dchain_limit #(.MAX_CHAIN(MAX_CHAIN), .CW(CW)) limit_i (
        .chain_len(nlen_q), .limit(limit)
    );

    assign pad_len  = CW'(nlen_q) << 2;
    assign bx_valid = (st != ST_IDLE);
    assign bx_tx    = (st == ST_SEND) ? fbyte : 8'h00;
    assign xfer     = bx_valid && bx_ready;

    // Request sequencing, counters and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cmd_q    <= 8'h00;
            addr_q   <= 8'h00;
            code_q   <= 8'h00;
            pay_q    <= '0;
            plen_q   <= '0;
            rlen_q   <= '0;
            nlen_q   <= '0;
            posted_q <= 1'b0;
            idx      <= '0;
            words    <= '0;
            done_q   <= 1'b0;
            ack_q    <= 1'b0;
            to_q     <= 1'b0;
            rsp_q    <= '0;
        end else begin
            done_q <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (req_start) begin
                        cmd_q    <= req_cmd;
                        addr_q   <= req_addr;
                        code_q   <= ack_code_of(req_cmd);
                        posted_q <= is_posted(req_cmd, req_addr);
                        pay_q    <= req_payload;
                        plen_q   <= req_pay_len;
                        rlen_q   <= req_rsp_len;
                        nlen_q   <= chain_len;
                        idx      <= '0;
                        words    <= '0;
                        ack_q    <= 1'b0;
                        to_q     <= 1'b0;
                        rsp_q    <= '0;
                        st       <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (xfer) begin
                        if (idx + CW'(1) == frame_len) begin
                            idx <= '0;
                            if (!posted_q) begin
                                st <= ST_POLL;
                            end else if (pad_len == '0) begin
                                st     <= ST_IDLE;
                                done_q <= 1'b1;
                                ack_q  <= 1'b1;
                            end else begin
                                st <= ST_PAD;
                            end
                        end else begin
                            idx <= idx + CW'(1);
                        end
                    end
                end
                ST_PAD: begin
                    if (xfer) begin
                        if (idx + CW'(1) == pad_len) begin
                            st     <= ST_IDLE;
                            done_q <= 1'b1;
                            ack_q  <= 1'b1;
                        end else begin
                            idx <= idx + CW'(1);
                        end
                    end
                end
                ST_POLL: begin
                    if (w_match) begin
                        idx <= '0;
                        if (rlen_q == '0) begin
                            st     <= ST_IDLE;
                            done_q <= 1'b1;
                            ack_q  <= 1'b1;
                        end else begin
                            st <= ST_RESP;
                        end
                    end else if (w_done) begin
                        if (words + CW'(1) == limit) begin
                            st     <= ST_IDLE;
                            done_q <= 1'b1;
                            to_q   <= 1'b1;
                        end else begin
                            words <= words + CW'(1);
                        end
                    end
                end
                ST_RESP: begin
                    if (xfer) begin
                        for (int i = 0; i < MAX_RSP; i++) begin
                            if (idx == CW'(i)) begin
                                rsp_q[i*8 +: 8] <= bx_rx;
                            end
                        end
                        if (idx + CW'(1) == CW'(rlen_q)) begin
                            st     <= ST_IDLE;
                            done_q <= 1'b1;
                            ack_q  <= 1'b1;
                        end else begin
                            idx <= idx + CW'(1);
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign done     = done_q;
    assign ack_ok   = ack_q;
    assign timeout  = to_q;
    assign rsp_data = rsp_q;

endmodule

// File: rtl/dchain_cmd_engine_chk.sv
// Protocol checker for the daisy-chain command engine, bound to every
// instance of the top module. Watches the byte port and the result flags.
module dchain_cmd_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_start,
    input logic       bx_valid,
    input logic [7:0] bx_tx,
    input logic       bx_ready,
    input logic       done,
    input logic       ack_ok,
    input logic       timeout
);

    // R7: an open exchange keeps its byte until the port answers.
    p_hold_until_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bx_valid && !bx_ready) |=> (bx_valid && $stable(bx_tx)));

    // R6: completion is a single-cycle pulse.
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: completion only follows a finished byte exchange.
    p_done_after_xfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(bx_valid && bx_ready));

    // R6: no transfer is requested in the cycle after completion unless restarted.
    p_idle_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bx_valid);

    // R3: timeout and acknowledge never coexist.
    p_flags_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_ok && timeout));

    // R6: flags hold while idle with no new start.
    p_flags_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!bx_valid && !req_start && !done) |=> ($stable(ack_ok) && $stable(timeout)));

endmodule

bind dchain_cmd_engine dchain_cmd_engine_chk chk_i (
    .clk(clk), .rst_n(rst_n), .req_start(req_start),
    .bx_valid(bx_valid), .bx_tx(bx_tx), .bx_ready(bx_ready),
    .done(done), .ack_ok(ack_ok), .timeout(timeout)
);

// File: tb/dchain_cmd_engine_tb.sv
`timescale 1ns/1ps
module dchain_cmd_engine_tb_top;

    localparam int MAX_PAY   = 56;
    localparam int MAX_RSP   = 8;
    localparam int MAX_CHAIN = 255;
    localparam int LW = $clog2(MAX_PAY + 1);
    localparam int RW = $clog2(MAX_RSP + 1);
    localparam int NW = $clog2(MAX_CHAIN + 1);
    localparam int QD = 4096;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 req_start = 1'b0;
    logic [7:0]           req_cmd = 8'h00;
    logic [7:0]           req_addr = 8'h00;
    logic [MAX_PAY*8-1:0] req_payload = '0;
    logic [LW-1:0]        req_pay_len = '0;
    logic [RW-1:0]        req_rsp_len = '0;
    logic [NW-1:0]        chain_len = '0;
    logic                 bx_valid;
    logic [7:0]           bx_tx;
    logic                 bx_ready = 1'b0;
    logic [7:0]           bx_rx = 8'h00;
    logic                 done, ack_ok, timeout;
    logic [MAX_RSP*8-1:0] rsp_data;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [7:0] rxq [QD];
    logic [7:0] txlog [QD];
    int n_xfer = 0;
    int stall = 0;

    always #4 clk = ~clk;

    dchain_cmd_engine #(.MAX_PAY(MAX_PAY), .MAX_RSP(MAX_RSP), .MAX_CHAIN(MAX_CHAIN)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_payload(req_payload), .req_pay_len(req_pay_len),
        .req_rsp_len(req_rsp_len), .chain_len(chain_len), .bx_valid(bx_valid),
        .bx_tx(bx_tx), .bx_ready(bx_ready), .bx_rx(bx_rx), .done(done),
        .ack_ok(ack_ok), .timeout(timeout), .rsp_data(rsp_data)
    );

    // Byte port model: random stall, logs sent bytes, returns queued bytes.
    initial begin
        forever begin
            @(negedge clk);
            bx_ready = 1'b0;
            if (bx_valid) begin
                if (stall == 0) begin
                    txlog[n_xfer % QD] = bx_tx;
                    bx_rx = rxq[n_xfer % QD];
                    bx_ready = 1'b1;
                    n_xfer++;
                    stall = $urandom % 3;
                end else begin
                    stall--;
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_code(input logic [7:0] c);
        return (c == 8'h0A) ? 8'h1A : c;
    endfunction

    function automatic bit exp_posted(input logic [7:0] c, input logic [7:0] a);
        return (c[3:0] == 4'h7) || (c == 8'h09 && a != 8'h00);
    endfunction

    function automatic int exp_limit(input int n);
        return 2 * n + 1 + ((n == 0) ? 510 : 0);
    endfunction

    task automatic run_txn(input logic [7:0] cmd, input logic [7:0] addr, input int len,
                           input int rlen, input int n, input int junk, input bit poke,
                           input string ack_tag);
        logic [7:0] pay [MAX_PAY];
        logic [7:0] etx [QD];
        logic [7:0] ec;
        logic [63:0] ersp;
        int fl, total, lim, pos, cyc, bad_frame, bad_dummy, n_after;
        bit posted, eack, eto, seen;
        ec = exp_code(cmd);
        posted = exp_posted(cmd, addr);
        fl = ((2 + len + 1) / 2) * 2;
        lim = exp_limit(n);
        ersp = '0;
        for (int i = 0; i < MAX_PAY; i++) pay[i] = 8'($urandom);
        for (int i = 0; i < QD; i++) begin
            etx[i] = 8'h00;
            rxq[i] = 8'hEE;
        end
        etx[0] = cmd;
        etx[1] = addr;
        for (int i = 0; i < len; i++) etx[i + 2] = pay[i];
        // Decoy acknowledge words while the frame is out (must be ignored).
        for (int i = 0; i < fl; i++) rxq[i] = (i % 2 == 0) ? ec : addr;
        pos = fl;
        eack = 1'b1;
        eto = 1'b0;
        if (posted) begin
            total = fl + 4 * n;
        end else begin
            for (int j = 0; j < junk && j < lim; j++) begin
                if (j % 3 == 2) begin
                    rxq[pos] = ec; rxq[pos + 1] = addr ^ 8'h01;
                end else if (j % 2 == 0) begin
                    rxq[pos] = 8'hE5; rxq[pos + 1] = ec;
                end else begin
                    rxq[pos] = addr; rxq[pos + 1] = 8'h3C;
                end
                pos += 2;
            end
            if (junk >= lim) begin
                eack = 1'b0;
                eto = 1'b1;
                total = pos;
            end else begin
                rxq[pos] = ec; rxq[pos + 1] = addr;
                pos += 2;
                for (int i = 0; i < rlen; i++) begin
                    rxq[pos] = 8'($urandom);
                    ersp[i*8 +: 8] = rxq[pos];
                    pos++;
                end
                total = pos;
            end
        end
        @(negedge clk);
        n_xfer = 0;
        req_cmd = cmd;
        req_addr = addr;
        for (int i = 0; i < MAX_PAY; i++) req_payload[i*8 +: 8] = pay[i];
        req_pay_len = LW'(len);
        req_rsp_len = RW'(rlen);
        chain_len = NW'(n);
        req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        seen = 1'b0;
        cyc = 0;
        while (!seen && cyc < 20000) begin
            if (done) seen = 1'b1;
            else begin
                if (poke && cyc == 3) begin
                    req_cmd = 8'h04; req_addr = 8'h00; req_start = 1'b1;
                end else begin
                    req_start = 1'b0;
                end
                @(negedge clk);
                cyc++;
            end
        end
        req_start = 1'b0;
        check(seen, "R6 done reached", {63'd0, seen}, 64'd1);
        if (!seen) return;
        check(ack_ok == eack, ack_tag, {63'd0, ack_ok}, {63'd0, eack});
        check(timeout == eto, "R3 timeout flag", {63'd0, timeout}, {63'd0, eto});
        check(rsp_data == ersp, "R4 response bytes", rsp_data, ersp);
        check(n_xfer == total, posted ? "R5 posted byte count" : "R7 byte count",
              64'(n_xfer), 64'(total));
        bad_frame = 0;
        bad_dummy = 0;
        for (int i = 0; i < n_xfer && i < QD; i++) begin
            if (i < fl && txlog[i] != etx[i]) bad_frame++;
            if (i >= fl && txlog[i] != 8'h00) bad_dummy++;
        end
        check(bad_frame == 0, "R1 frame bytes", 64'(bad_frame), 64'd0);
        check(bad_dummy == 0, "R2 dummy bytes zero", 64'(bad_dummy), 64'd0);
        @(negedge clk);
        check(!done, "R6 done one cycle", {63'd0, done}, 64'd0);
        n_after = n_xfer;
        repeat (4) @(negedge clk);
        check(n_xfer == n_after && !bx_valid, "R6 idle after done", 64'(n_xfer), 64'(n_after));
        check(ack_ok == eack && timeout == eto, "R6 flags held",
              {62'd0, ack_ok, timeout}, {62'd0, eack, eto});
    endtask

    // Global watchdog.
    initial begin
        #(200000 * 8);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] cmds [6];
        void'($urandom(32'd4242));
        for (int i = 0; i < QD; i++) rxq[i] = 8'h00;
        repeat (3) @(negedge clk);
        check(!done && !ack_ok && !timeout && !bx_valid && rsp_data == '0,
              "R6 reset state", {60'd0, done, ack_ok, timeout, bx_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // Directed cases.
        run_txn(8'h04, 8'h00, 0, 0, 3, 2, 1'b0, "R2 broadcast reset ack");
        run_txn(8'h0A, 8'h02, 0, 6, 4, 3, 1'b0, "R2 register read ack code");
        run_txn(8'h01, 8'h00, 0, 2, 0, 400, 1'b0, "R3 unknown chain long hunt");
        run_txn(8'h08, 8'h05, 0, 0, 2, 5, 1'b0, "R3 timeout at limit");
        run_txn(8'h08, 8'h05, 0, 0, 2, 4, 1'b0, "R3 ack in last word");
        run_txn(8'h01, 8'h00, 0, 0, 0, 511, 1'b0, "R3 timeout unknown chain");
        run_txn(8'h27, 8'h03, 56, 0, 5, 0, 1'b0, "R5 write job posted");
        run_txn(8'h09, 8'h01, 6, 0, 2, 0, 1'b0, "R5 unicast register write");
        run_txn(8'h09, 8'h00, 6, 6, 2, 1, 1'b0, "R5 broadcast write acked");
        run_txn(8'h17, 8'h04, 56, 0, 0, 0, 1'b0, "R5 posted no chain pad");
        run_txn(8'h03, 8'h00, 3, 0, 3, 2, 1'b0, "R1 odd payload");
        run_txn(8'h0A, 8'h06, 0, 8, 6, 6, 1'b0, "R8 straddled decoys");
        run_txn(8'h0A, 8'h07, 0, 4, 3, 2, 1'b1, "R6 start ignored when busy");
        // Random mix.
        cmds[0] = 8'h01; cmds[1] = 8'h03; cmds[2] = 8'h04;
        cmds[3] = 8'h08; cmds[4] = 8'h09; cmds[5] = 8'h0A;
        for (int t = 0; t < 20; t++) begin
            int n, lm;
            logic [7:0] c, a;
            c = cmds[$urandom % 6];
            a = 8'($urandom % 32);
            if (t % 5 == 4) c = {4'($urandom % 5), 4'h7};
            n = $urandom % 12;
            lm = 2 * n + 1 + ((n == 0) ? 510 : 0);
            run_txn(c, a, $urandom % (MAX_PAY + 1), $urandom % (MAX_RSP + 1), n,
                    $urandom % (lm + 2), ($urandom % 4) == 0, "R2 random ack");
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule